// File: doc/BRIEF.md
# Synthesizer Configuration Loader

This block holds the frequency-plan settings of a clock synthesizer and updates them from two sources. The first is a three-wire serial port made of a serial clock, a data line and a load strobe. Bits go into a 14-bit shift register, and a falling edge of the load strobe commits the collected word. The second source is a parallel word that a rising edge of a parallel strobe commits. That word holds a 9-bit feedback multiplier and a 2-bit post-divider code, and it forces the test selection to a fixed value.

The block presents four outputs:
- the committed multiplier;
- the divider code;
- the decoded divide ratio;
- a 3-bit selection for a small test multiplexer over internal digital nodes.

All four strobe and data inputs pass through a synchronizer into the system clock domain. A small state machine arbitrates between the two paths and gives the parallel path priority. It has three states: `ST_IDLE`, `ST_SER_COMMIT` and `ST_PAR_COMMIT`.

State machine transitions, evaluated every cycle from any state:
- A parallel rising edge goes to `ST_PAR_COMMIT`.
- Otherwise, an accepted serial load goes to `ST_SER_COMMIT`.
- Otherwise, the machine goes to `ST_IDLE`.

Both commit states copy the staged word into the configuration registers on one clock edge, so every output field changes in the same cycle.

Top module: `synth_cfg_ctrl`

## Requirements
- R1: After reset the multiplier reads 511, the divider code reads 3, the test select reads 0 and the divide ratio reads 8.
- R2: The serial word is shifted in MSB first with fields, from first bit to last: test select (3 bits), divider code (2 bits), multiplier (9 bits). A falling edge of `ser_load_i` commits the word.
- R3: The shift register moves one place only on a rising edge of `ser_clk_i` and keeps the last 14 bits, so earlier excess bits are dropped.
- R4: Shifting bits without a load strobe, and the rising edge of `ser_load_i`, leave the committed configuration unchanged.
- R5: A rising edge of `par_load_i` commits `par_m_i` and `par_n_i` and sets the test select to the parameter `PAR_TEST` (default 0).
- R6: A parallel input bit whose `par_driven_i` bit is 0 reads as 1. Bits [8:0] of `par_driven_i` cover the multiplier and bits [10:9] cover the divider code.
- R7: When a parallel rising edge and a serial falling edge reach the arbiter in the same cycle, the parallel values are committed.
- R8: A serial load falling edge is ignored while `par_load_i` is high.
- R9: The divider code decodes as 0 to ratio 1, 1 to ratio 2, 2 to ratio 4 and 3 to ratio 8. `div_ratio_o` carries that value in binary.
- R10: `test_o` shows one node, chosen by the test select:
  - 0: constant 0
  - 1: shift register MSB
  - 2: synchronized serial clock
  - 3: synchronized serial load
  - 4: synchronized parallel load
  - 5: a one-cycle tick every ratio cycles
  - 6: XOR of the multiplier bits
  - 7: constant 1
- R11: The configuration outputs change only on the clock edge that ends a commit state.
- R12: If `par_load_i` is held high through reset, the parallel word is committed after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_data_i | input | 1 | Serial data bit |
| ser_load_i | input | 1 | Serial commit strobe; acts on its falling edge |
| par_load_i | input | 1 | Parallel commit strobe; acts on its rising edge |
| par_m_i | input | 9 | Parallel multiplier value |
| par_n_i | input | 2 | Parallel divider code |
| par_driven_i | input | 11 | Per-bit drive flags for the parallel word; 0 reads as 1 |
| cfg_m_o | output | 9 | Committed multiplier |
| cfg_n_o | output | 2 | Committed divider code |
| cfg_t_o | output | 3 | Committed test select |
| div_ratio_o | output | 4 | Decoded divide ratio (1, 2, 4 or 8) |
| test_o | output | 1 | Test multiplexer output |

## Verification
The bench builds the block with its default widths: 9-bit multiplier, 2-bit code, 3-bit test select and two synchronizer stages. At these widths all four divider codes and all eight test selections can be swept. Each divider code is paired with several multiplier patterns on both load paths, and the expected fields and ratios are computed arithmetically. The small field widths also make the corner cases cheap to reach:
- surplus serial bits;
- partially driven parallel words;
- simultaneous strobes;
- a parallel strobe held across reset.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_SER_COMMIT = 2'd1,
        ST_PAR_COMMIT = 2'd2
    } cfg_state_e;

    typedef enum logic [2:0] {
        TS_LOW      = 3'd0,
        TS_SR_MSB   = 3'd1,
        TS_SCLK     = 3'd2,
        TS_SLOAD    = 3'd3,
        TS_PLOAD    = 3'd4,
        TS_DIV_TICK = 3'd5,
        TS_M_PARITY = 3'd6,
        TS_HIGH     = 3'd7
    } test_sel_e;

    localparam int IN_SCLK  = 0;
    localparam int IN_SDATA = 1;
    localparam int IN_SLOAD = 2;
    localparam int IN_PLOAD = 3;
    localparam int IN_COUNT = 4;

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[W-2:0], bit_in};
    end

    assign word_o = sr_q;
endmodule

// File: rtl/post_div_model.sv
module post_div_model #(
    parameter int N_W = 2,
    localparam int RATIO_W = 1 << N_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_W-1:0]     code_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               tick_o
);
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] last;

    assign ratio_o = RATIO_W'(1) << code_i;
    assign last    = ratio_o - RATIO_W'(1);
    assign tick_o  = (cnt_q >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + RATIO_W'(1);
    end
endmodule

// File: rtl/test_node_mux.sv
module test_node_mux #(
    parameter int T_W = 3,
    localparam int NODES = 1 << T_W
) (
    input  logic [T_W-1:0]   sel_i,
    input  logic [NODES-1:0] nodes_i,
    output logic             out_o
);
    assign out_o = nodes_i[sel_i];
endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
    import synth_cfg_pkg::*;
#(
    parameter int M_W         = 9,
    parameter int N_W         = 2,
    parameter int T_W         = 3,
    parameter int SYNC_STAGES = 2,
    parameter logic [T_W-1:0] PAR_TEST = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk_i,
    input  logic                  ser_data_i,
    input  logic                  ser_load_i,
    input  logic                  par_load_i,
    input  logic [M_W-1:0]        par_m_i,
    input  logic [N_W-1:0]        par_n_i,
    input  logic [M_W+N_W-1:0]    par_driven_i,
    output logic [M_W-1:0]        cfg_m_o,
    output logic [N_W-1:0]        cfg_n_o,
    output logic [T_W-1:0]        cfg_t_o,
    output logic [(1<<N_W)-1:0]   div_ratio_o,
    output logic                  test_o
);
    localparam int SR_W    = T_W + N_W + M_W;
    localparam int RATIO_W = 1 << N_W;
    localparam int NODES   = 1 << T_W;

    // ---------------- input synchronizers ----------------
    logic [IN_COUNT-1:0] async_in;
    logic [IN_COUNT-1:0] lvl;

    assign async_in[IN_SCLK]  = ser_clk_i;
    assign async_in[IN_SDATA] = ser_data_i;
    assign async_in[IN_SLOAD] = ser_load_i;
    assign async_in[IN_PLOAD] = par_load_i;

    for (genvar gi = 0; gi < IN_COUNT; gi++) begin : g_sync
        sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (async_in[gi]),
            .level_o (lvl[gi])
        );
    end

    // ---------------- edge detection ----------------
    logic sclk_prev_q, sload_prev_q, pload_prev_q;
    logic ser_rise, ser_fall, par_rise, ser_take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q  <= 1'b0;
            sload_prev_q <= 1'b0;
            pload_prev_q <= 1'b0;
        end else begin
            sclk_prev_q  <= lvl[IN_SCLK];
            sload_prev_q <= lvl[IN_SLOAD];
            pload_prev_q <= lvl[IN_PLOAD];
        end
    end

    assign ser_rise = lvl[IN_SCLK] & ~sclk_prev_q;
    assign ser_fall = ~lvl[IN_SLOAD] & sload_prev_q;
    assign par_rise = lvl[IN_PLOAD] & ~pload_prev_q;
    assign ser_take = ser_fall & ~lvl[IN_PLOAD];

    // ---------------- serial shift register ----------------
    logic [SR_W-1:0] sr_word;

    cfg_shift_reg #(.W(SR_W)) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (ser_rise),
        .bit_in   (lvl[IN_SDATA]),
        .word_o   (sr_word)
    );

    // ---------------- parallel word with pull-up model ----------------
    logic [M_W+N_W-1:0] par_raw, par_eff;
    assign par_raw = {par_n_i, par_m_i};
    assign par_eff = par_raw | ~par_driven_i;

    // ---------------- staging register ----------------
    logic [SR_W-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend_q <= '1;
        else if (par_rise) pend_q <= {PAR_TEST, par_eff};
        else if (ser_take) pend_q <= sr_word;
    end

    // ---------------- arbitration state machine ----------------
    cfg_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (par_rise)      state_d = ST_PAR_COMMIT;
                else if (ser_take) state_d = ST_SER_COMMIT;
                else               state_d = ST_IDLE;
            end
            ST_SER_COMMIT: begin
                if (par_rise)      state_d = ST_PAR_COMMIT;
                else if (ser_take) state_d = ST_SER_COMMIT;
                else               state_d = ST_IDLE;
            end
            ST_PAR_COMMIT: begin
                if (par_rise)      state_d = ST_PAR_COMMIT;
                else if (ser_take) state_d = ST_SER_COMMIT;
                else               state_d = ST_IDLE;
            end
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- configuration outputs ----------------
    logic [M_W-1:0] m_q;
    logic [N_W-1:0] n_q;
    logic [T_W-1:0] t_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '1;
            n_q <= '1;
            t_q <= '0;
        end else begin
            unique case (state_q)
                ST_SER_COMMIT,
                ST_PAR_COMMIT: {t_q, n_q, m_q} <= pend_q;
                default: ;
            endcase
        end
    end

    assign cfg_m_o = m_q;
    assign cfg_n_o = n_q;
    assign cfg_t_o = t_q;

    // ---------------- divider model and test mux ----------------
    logic div_tick;

    post_div_model #(.N_W(N_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_i  (n_q),
        .ratio_o (div_ratio_o),
        .tick_o  (div_tick)
    );

    logic [NODES-1:0] nodes;
    always_comb begin
        nodes              = '0;
        nodes[TS_LOW]      = 1'b0;
        nodes[TS_SR_MSB]   = sr_word[SR_W-1];
        nodes[TS_SCLK]     = lvl[IN_SCLK];
        nodes[TS_SLOAD]    = lvl[IN_SLOAD];
        nodes[TS_PLOAD]    = lvl[IN_PLOAD];
        nodes[TS_DIV_TICK] = div_tick;
        nodes[TS_M_PARITY] = ^m_q;
        nodes[TS_HIGH]     = 1'b1;
    end

    test_node_mux #(.T_W(T_W)) u_mux (
        .sel_i   (t_q),
        .nodes_i (nodes),
        .out_o   (test_o)
    );
endmodule

// File: rtl/synth_cfg_checks.sv
module synth_cfg_checks
    import synth_cfg_pkg::*;
#(
    parameter int M_W = 9,
    parameter int N_W = 2,
    parameter int T_W = 3,
    parameter logic [T_W-1:0] PAR_TEST = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input cfg_state_e            state,
    input logic                  par_rise,
    input logic                  ser_fall,
    input logic                  ser_rise,
    input logic                  par_lvl,
    input logic [T_W+N_W+M_W-1:0] sr,
    input logic [M_W-1:0]        cfg_m,
    input logic [N_W-1:0]        cfg_n,
    input logic [T_W-1:0]        cfg_t,
    input logic [(1<<N_W)-1:0]   ratio
);
    assert_ratio_single_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ratio) == 1);

    assert_cfg_moves_on_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cfg_t, cfg_n, cfg_m}) |-> ($past(state) != ST_IDLE));

    assert_par_beats_ser_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (par_rise && ser_fall) |=> (state == ST_PAR_COMMIT));

    assert_par_forces_test_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAR_COMMIT) |=> (cfg_t == PAR_TEST));

    assert_ser_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_fall && par_lvl && !par_rise) |=> (state == ST_IDLE));

    assert_shift_only_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_rise |=> $stable(sr));
endmodule

bind synth_cfg_ctrl synth_cfg_checks #(
    .M_W(M_W), .N_W(N_W), .T_W(T_W), .PAR_TEST(PAR_TEST)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .par_rise (par_rise),
    .ser_fall (ser_fall),
    .ser_rise (ser_rise),
    .par_lvl  (lvl[3]),
    .sr       (sr_word),
    .cfg_m    (cfg_m_o),
    .cfg_n    (cfg_n_o),
    .cfg_t    (cfg_t_o),
    .ratio    (div_ratio_o)
);

// File: tb/tb_synth_cfg_ctrl.sv
`timescale 1ns/1ps
module tb_synth_cfg_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk_i = 1'b0, ser_data_i = 1'b0, ser_load_i = 1'b0, par_load_i = 1'b0;
    logic [8:0]  par_m_i = '0;
    logic [1:0]  par_n_i = '0;
    logic [10:0] par_driven_i = '1;
    logic [8:0]  cfg_m_o;
    logic [1:0]  cfg_n_o;
    logic [2:0]  cfg_t_o;
    logic [3:0]  div_ratio_o;
    logic        test_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    synth_cfg_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk_i), .ser_data_i(ser_data_i), .ser_load_i(ser_load_i),
        .par_load_i(par_load_i), .par_m_i(par_m_i), .par_n_i(par_n_i),
        .par_driven_i(par_driven_i),
        .cfg_m_o(cfg_m_o), .cfg_n_o(cfg_n_o), .cfg_t_o(cfg_t_o),
        .div_ratio_o(div_ratio_o), .test_o(test_o)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ser_bit(input logic b);
        ser_data_i = b; tick(3);
        ser_clk_i = 1'b1; tick(4);
        ser_clk_i = 1'b0; tick(3);
    endtask

    task automatic ser_word(input logic [13:0] w);
        for (int i = 13; i >= 0; i--) ser_bit(w[i]);
    endtask

    task automatic ser_strobe();
        ser_load_i = 1'b1; tick(5);
        ser_load_i = 1'b0; tick(8);
    endtask

    task automatic par_strobe(input logic [8:0] m, input logic [1:0] n);
        par_m_i = m; par_n_i = n; tick(3);
        par_load_i = 1'b1; tick(8);
        par_load_i = 1'b0; tick(4);
    endtask

    task automatic check_cfg(input string req, input int m, input int n, input int t);
        check({req, " mult"}, cfg_m_o, m);
        check({req, " code"}, cfg_n_o, n);
        check({req, " tsel"}, cfg_t_o, t);
        check({req, " ratio"}, div_ratio_o, 1 << n);
    endtask

    initial begin
        #(1_500_000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int mvals[5];
        mvals = '{0, 1, 341, 511, 170};
        tick(5);
        rst_n = 1'b1;
        tick(6);
        // R1 reset values
        check_cfg("R1", 511, 3, 0);

        // R2 / R9 serial sweep over every divider code
        for (int n = 0; n < 4; n++) begin
            for (int k = 0; k < 5; k++) begin
                int t;
                t = (n * 3 + k) % 8;
                ser_word({t[2:0], n[1:0], mvals[k][8:0]});
                ser_strobe();
                check_cfg("R2/R9", mvals[k], n, t);
            end
        end

        // R3 surplus leading bits are dropped
        ser_bit(1'b1); ser_bit(1'b0);
        ser_word({3'd2, 2'd1, 9'd77});
        ser_strobe();
        check_cfg("R3", 77, 1, 2);

        // R4 shifting alone and load rise change nothing
        ser_word({3'd5, 2'd3, 9'd300});
        check_cfg("R4 shift-only", 77, 1, 2);
        ser_load_i = 1'b1; tick(8);
        check_cfg("R4 load-high", 77, 1, 2);
        ser_load_i = 1'b0; tick(8);
        check_cfg("R4 load-fall", 300, 3, 5);

        // R10 test multiplexer sweep (code 1 -> ratio 2)
        for (int t = 0; t < 8; t++) begin
            logic [13:0] w;
            w = {t[2:0], 2'd1, 9'h0B3};
            ser_word(w);
            ser_strobe();
            case (t)
                0: check("R10 sel0", test_o, 0);
                1: check("R10 sel1", test_o, w[13]);
                2: check("R10 sel2", test_o, 0);
                3: check("R10 sel3", test_o, 0);
                4: check("R10 sel4", test_o, 0);
                5: begin
                    int cnt;
                    cnt = 0;
                    for (int c = 0; c < 16; c++) begin
                        cnt += test_o; tick(1);
                    end
                    check("R10 sel5 ratio2", cnt, 8);
                end
                6: check("R10 sel6", test_o, ^9'h0B3);
                default: check("R10 sel7", test_o, 1);
            endcase
        end
        ser_word({3'd5, 2'd3, 9'd9});
        ser_strobe();
        begin
            int cnt;
            cnt = 0;
            for (int c = 0; c < 16; c++) begin
                cnt += test_o; tick(1);
            end
            check("R10 sel5 ratio8", cnt, 2);
        end

        // R5 parallel sweep
        for (int n = 0; n < 4; n++) begin
            for (int k = 0; k < 5; k += 2) begin
                par_strobe(mvals[k][8:0], n[1:0]);
                check_cfg("R5", mvals[k], n, 0);
            end
        end

        // R6 undriven bits read high
        par_driven_i = 11'b000_0000_1111;
        par_strobe(9'd0, 2'd0);
        check_cfg("R6", 9'h1F0, 3, 0);
        par_driven_i = '1;

        // R8 serial load ignored while parallel strobe high
        par_m_i = 9'd33; par_n_i = 2'd2; tick(3);
        par_load_i = 1'b1; tick(8);
        check_cfg("R8 par", 33, 2, 0);
        ser_word({3'd7, 2'd0, 9'd444});
        ser_strobe();
        check_cfg("R8 ser blocked", 33, 2, 0);
        par_load_i = 1'b0; tick(6);

        // R7 simultaneous strobes: parallel wins
        ser_word({3'd6, 2'd1, 9'd200});
        ser_load_i = 1'b1;
        par_m_i = 9'd123; par_n_i = 2'd0; tick(6);
        ser_load_i = 1'b0; par_load_i = 1'b1; tick(10);
        check_cfg("R7", 123, 0, 0);
        par_load_i = 1'b0; tick(6);

        // R12 parallel strobe held through reset
        rst_n = 1'b0; par_m_i = 9'd258; par_n_i = 2'd1; par_load_i = 1'b1;
        tick(4);
        rst_n = 1'b1;
        tick(10);
        check_cfg("R12", 258, 1, 0);
        par_load_i = 1'b0; tick(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule